// File: doc/BRIEF.md
# Power-On Initialization and Self-Test Sequencer

This block steps a processor through the interval between its reset pin being released and the moment the processor starts running user code. While reset is held, a counter measures how long the pin stays asserted. When reset is released, that count is compared against the minimum the selected clock mode demands: 16 cycles with the divide-by-two input clock, 10,000 cycles with the undivided input clock. A hold that was too short raises a sticky flag, but the sequence still runs, so the violation can be observed.

In the normal flow the sequencer raises the fail pin and starts the internal self-test engine. On a pass it drops the fail pin for one cycle. It then raises the fail pin again and starts the external bus confidence test. On a pass the fail pin drops for good and a one-cycle strobe tells the core to branch to user initialization code. If either test fails, the fail pin stays high and the sequencer stops until the next reset. A strap input disables both the self-testing and the fail-pin signalling; with the strap set, the user-code strobe follows reset release at once. Asserting the reset pin again at any time abandons the sequence.

Top module: `rst_selftest_seq`

## Requirements
- R1: At the clock edge after any edge that samples `rst_pin` high, `fail_o`, `ist_start_o`, `bus_start_o`, `user_go_o` and `short_rst_o` are all 0.
- R2: The release edge is the first edge that samples `rst_pin` low after a reset. At that edge, `short_rst_o` becomes 1 if fewer than the required number of edges sampled `rst_pin` high. The requirement is 16 edges when `clk_mode_1x` is 0 and 10,000 edges when it is 1. The flag then holds its value until reset is asserted again, and a short hold does not stop the sequence.
- R3: The hold-width counter is 14 bits wide and saturates at its top value rather than wrapping, so a hold of 17,000 edges in the 1x mode does not flag a short reset.
- R4: With `bist_skip` at 0, the cycle after the release edge has `fail_o`=1 and a one-cycle `ist_start_o` pulse.
- R5: When `ist_done` and `ist_pass` are sampled high while the internal test is awaited, `fail_o` is 0 for exactly the next cycle. In the cycle after that, `bus_start_o` pulses for one cycle with `fail_o`=1.
- R6: When `ist_done`=1 and `ist_pass`=0 are sampled while the internal test is awaited, `fail_o` stays 1. No test start and no `user_go_o` follow until reset, even if pass results arrive later.
- R7: When `bus_done` and `bus_pass` are sampled high while the bus test is awaited, the next cycle has `user_go_o`=1 and `fail_o`=0. After that `user_go_o` is 0 and `fail_o` stays 0.
- R8: When `bus_done`=1 and `bus_pass`=0 are sampled while the bus test is awaited, `fail_o` stays 1 and `user_go_o` is never pulsed.
- R9: With `bist_skip`=1 at the release edge, the cycle after release has `user_go_o`=1. `fail_o`, `ist_start_o` and `bus_start_o` stay 0 throughout.
- R10: Reasserting `rst_pin` in the middle of a sequence brings every output to 0 at the next edge (see R1). A later release starts the sequence again from R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_pin | input | 1 | Reset pin, active high, sampled on clk |
| clk_mode_1x | input | 1 | 1 selects the undivided clock mode (10,000-cycle minimum), 0 selects divide-by-two (16) |
| bist_skip | input | 1 | Strap that bypasses self-testing and fail signalling |
| ist_done | input | 1 | Internal self-test finished |
| ist_pass | input | 1 | Internal self-test result, valid with ist_done |
| bus_done | input | 1 | External bus confidence test finished |
| bus_pass | input | 1 | Bus test result, valid with bus_done |
| fail_o | output | 1 | Fail indicator pin |
| ist_start_o | output | 1 | One-cycle start strobe for the internal self-test |
| bus_start_o | output | 1 | One-cycle start strobe for the bus test |
| user_go_o | output | 1 | One-cycle strobe to begin user initialization code |
| short_rst_o | output | 1 | Sticky flag: last reset hold was too short |

## Verification
A state register stuck or skipped in this block shows up on the fail pin within one cycle of the test result that should have moved it. Symptoms include a missing one-cycle low gap between the two tests, a bus strobe after an internal failure, or a user-code strobe that arrives early or never. A wrong hold count or threshold is visible only through `short_rst_o`, in the cycle right after release. Both sides of each threshold are driven, as well as a hold longer than the 1x threshold, which exposes a counter that wraps. An abort mid-sequence that fails to clear the state shows up as a stale output one edge after reset is reasserted.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [3:0] {
    SQ_RESET,
    SQ_IST_GO,
    SQ_IST_WAIT,
    SQ_GAP,
    SQ_BUS_GO,
    SQ_BUS_WAIT,
    SQ_USER,
    SQ_RUN,
    SQ_HALT
  } seq_state_t;

  // Minimum number of sampled reset cycles for the selected clock mode.
  function automatic int unsigned min_hold(input logic mode_1x,
                                           input int unsigned need_1x,
                                           input int unsigned need_2x);
    return mode_1x ? need_1x : need_2x;
  endfunction

  // True when the observed hold falls below the requirement.
  function automatic logic hold_too_short(input int unsigned seen,
                                          input int unsigned need);
    return seen < need;
  endfunction

  // Saturating increment of an unsigned count held in 32 bits.
  function automatic int unsigned sat_inc(input int unsigned v,
                                          input int unsigned top);
    return (v >= top) ? top : v + 1;
  endfunction

endpackage

// File: rtl/rst_width_mon.sv
module rst_width_mon
  import rst_seq_pkg::*;
#(
  parameter int unsigned CNT_W  = 14,
  parameter int unsigned MIN_1X = 10000,
  parameter int unsigned MIN_2X = 16
) (
  input  logic clk,
  input  logic rst_pin,
  input  logic clk_mode_1x,
  input  logic release_evt,
  output logic short_rst
);

  localparam int unsigned CNT_TOP = (1 << CNT_W) - 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             short_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             hold_short;

  assign cnt_inc    = CNT_W'(sat_inc(32'(cnt_q), CNT_TOP));
  assign hold_short = hold_too_short(32'(cnt_q),
                                     min_hold(clk_mode_1x, MIN_1X, MIN_2X));

  always_ff @(posedge clk) begin
    if (rst_pin) begin
      cnt_q   <= cnt_inc;
      short_q <= 1'b0;
    end else begin
      cnt_q <= '0;
      if (release_evt) short_q <= hold_short;
    end
  end

  assign short_rst = short_q;

  // R3
  cnt_sat_chk: assert property (@(posedge clk)
    (rst_pin && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX || cnt_q == '0));

  // R2
  short_sticky_chk: assert property (@(posedge clk)
    (!rst_pin && !release_evt) |=> $stable(short_q));

  // R1
  short_clear_chk: assert property (@(posedge clk)
    rst_pin |=> !short_q);

endmodule

// File: rtl/rst_init_fsm.sv
module rst_init_fsm
  import rst_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_pin,
  input  logic skip_strap,
  input  logic ist_done,
  input  logic ist_pass,
  input  logic bus_done,
  input  logic bus_pass,
  output logic fail_o,
  output logic ist_start,
  output logic bus_start,
  output logic user_go,
  output logic release_evt
);

  seq_state_t state_q, state_d;
  logic       ist_ok_evt, ist_bad_evt, bus_ok_evt, bus_bad_evt;
  logic       skip_q;

  assign release_evt = (state_q == SQ_RESET) && !rst_pin;
  assign ist_ok_evt  = (state_q == SQ_IST_WAIT) && ist_done && ist_pass;
  assign ist_bad_evt = (state_q == SQ_IST_WAIT) && ist_done && !ist_pass;
  assign bus_ok_evt  = (state_q == SQ_BUS_WAIT) && bus_done && bus_pass;
  assign bus_bad_evt = (state_q == SQ_BUS_WAIT) && bus_done && !bus_pass;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_RESET:    state_d = skip_strap ? SQ_USER : SQ_IST_GO;
      SQ_IST_GO:   state_d = SQ_IST_WAIT;
      SQ_IST_WAIT: begin
        if (ist_ok_evt)       state_d = SQ_GAP;
        else if (ist_bad_evt) state_d = SQ_HALT;
      end
      SQ_GAP:      state_d = SQ_BUS_GO;
      SQ_BUS_GO:   state_d = SQ_BUS_WAIT;
      SQ_BUS_WAIT: begin
        if (bus_ok_evt)       state_d = SQ_USER;
        else if (bus_bad_evt) state_d = SQ_HALT;
      end
      SQ_USER:     state_d = SQ_RUN;
      SQ_RUN:      state_d = SQ_RUN;
      SQ_HALT:     state_d = SQ_HALT;
      default:     state_d = SQ_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst_pin) begin
      state_q <= SQ_RESET;
      skip_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (release_evt) skip_q <= skip_strap;
    end
  end

  always_comb begin
    fail_o    = 1'b0;
    ist_start = 1'b0;
    bus_start = 1'b0;
    user_go   = 1'b0;
    unique case (state_q)
      SQ_IST_GO:   begin fail_o = 1'b1; ist_start = 1'b1; end
      SQ_IST_WAIT: fail_o = 1'b1;
      SQ_BUS_GO:   begin fail_o = 1'b1; bus_start = 1'b1; end
      SQ_BUS_WAIT: fail_o = 1'b1;
      SQ_HALT:     fail_o = 1'b1;
      SQ_USER:     user_go = 1'b1;
      default:     ;
    endcase
  end

  // R4
  ist_fail_high_chk: assert property (@(posedge clk) disable iff (rst_pin)
    (release_evt && !skip_strap) |=> (ist_start && fail_o));

  // R5
  gap_low_chk: assert property (@(posedge clk) disable iff (rst_pin)
    ist_ok_evt |=> (!fail_o && !bus_start));

  // R6
  ist_halt_chk: assert property (@(posedge clk) disable iff (rst_pin)
    ist_bad_evt |=> (fail_o && !bus_start && !user_go));

  // R7
  user_go_chk: assert property (@(posedge clk) disable iff (rst_pin)
    bus_ok_evt |=> (user_go && !fail_o));

  // R8
  bus_halt_chk: assert property (@(posedge clk) disable iff (rst_pin)
    bus_bad_evt |=> (fail_o && !user_go));

  // R9
  bypass_go_chk: assert property (@(posedge clk) disable iff (rst_pin)
    (release_evt && skip_strap) |=> (user_go && !fail_o));

  // R9
  bypass_quiet_chk: assert property (@(posedge clk) disable iff (rst_pin)
    skip_q |-> (!fail_o && !ist_start && !bus_start));

endmodule

// File: rtl/rst_selftest_seq.sv
module rst_selftest_seq
  import rst_seq_pkg::*;
#(
  parameter int unsigned CNT_W  = 14,
  parameter int unsigned MIN_1X = 10000,
  parameter int unsigned MIN_2X = 16
) (
  input  logic clk,
  input  logic rst_pin,
  input  logic clk_mode_1x,
  input  logic bist_skip,
  input  logic ist_done,
  input  logic ist_pass,
  input  logic bus_done,
  input  logic bus_pass,
  output logic fail_o,
  output logic ist_start_o,
  output logic bus_start_o,
  output logic user_go_o,
  output logic short_rst_o
);

  logic release_evt;

  rst_init_fsm u_fsm (
    .clk         (clk),
    .rst_pin     (rst_pin),
    .skip_strap  (bist_skip),
    .ist_done    (ist_done),
    .ist_pass    (ist_pass),
    .bus_done    (bus_done),
    .bus_pass    (bus_pass),
    .fail_o      (fail_o),
    .ist_start   (ist_start_o),
    .bus_start   (bus_start_o),
    .user_go     (user_go_o),
    .release_evt (release_evt)
  );

  rst_width_mon #(
    .CNT_W  (CNT_W),
    .MIN_1X (MIN_1X),
    .MIN_2X (MIN_2X)
  ) u_mon (
    .clk         (clk),
    .rst_pin     (rst_pin),
    .clk_mode_1x (clk_mode_1x),
    .release_evt (release_evt),
    .short_rst   (short_rst_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst_pin |=> (!fail_o && !ist_start_o && !bus_start_o && !user_go_o));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst_pin)
    $onehot0({ist_start_o, bus_start_o, user_go_o}));

endmodule

// File: tb/rst_selftest_seq_tb_top.sv
`timescale 1ns/1ps
module rst_selftest_seq_tb_top;

  logic clk = 1'b0;
  logic rst_pin = 1'b1;
  logic clk_mode_1x = 1'b0;
  logic bist_skip = 1'b0;
  logic ist_done = 1'b0, ist_pass = 1'b0, bus_done = 1'b0, bus_pass = 1'b0;
  logic fail_o, ist_start_o, bus_start_o, user_go_o, short_rst_o;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rst_selftest_seq dut_i (
    .clk(clk), .rst_pin(rst_pin), .clk_mode_1x(clk_mode_1x), .bist_skip(bist_skip),
    .ist_done(ist_done), .ist_pass(ist_pass), .bus_done(bus_done), .bus_pass(bus_pass),
    .fail_o(fail_o), .ist_start_o(ist_start_o), .bus_start_o(bus_start_o),
    .user_go_o(user_go_o), .short_rst_o(short_rst_o)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Holds reset for exactly n sampling edges, then releases at a negedge.
  task automatic apply_reset(input int n, input logic mode, input logic skip);
    @(negedge clk);
    clk_mode_1x = mode;
    bist_skip   = skip;
    rst_pin     = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    rst_pin = 1'b0;
  endtask

  // Short-reset threshold: which sides of the limit raise the flag.
  function automatic logic expect_short(input int n, input logic mode);
    int need;
    need = mode ? 10000 : 16;
    return n < need;
  endfunction

  task automatic t_reset_state();
    @(negedge clk);
    rst_pin = 1'b1;
    repeat (3) step();
    check("R1", "fail_o in reset", fail_o, 1'b0);
    check("R1", "ist_start_o in reset", ist_start_o, 1'b0);
    check("R1", "user_go_o in reset", user_go_o, 1'b0);
    check("R1", "short_rst_o in reset", short_rst_o, 1'b0);
  endtask

  task automatic t_full_pass();
    apply_reset(16, 1'b0, 1'b0);
    step();
    check("R4", "fail_o after release", fail_o, 1'b1);
    check("R4", "ist_start_o after release", ist_start_o, 1'b1);
    check("R2", "short_rst_o at 16 in 2x", short_rst_o, expect_short(16, 1'b0));
    step();
    check("R4", "ist_start_o one cycle", ist_start_o, 1'b0);
    check("R4", "fail_o while testing", fail_o, 1'b1);
    ist_done = 1'b1; ist_pass = 1'b1;
    step();
    ist_done = 1'b0; ist_pass = 1'b0;
    check("R5", "fail_o gap", fail_o, 1'b0);
    check("R5", "bus_start_o in gap", bus_start_o, 1'b0);
    step();
    check("R5", "bus_start_o", bus_start_o, 1'b1);
    check("R5", "fail_o reasserted", fail_o, 1'b1);
    step();
    check("R5", "bus_start_o one cycle", bus_start_o, 1'b0);
    bus_done = 1'b1; bus_pass = 1'b1;
    step();
    bus_done = 1'b0; bus_pass = 1'b0;
    check("R7", "user_go_o", user_go_o, 1'b1);
    check("R7", "fail_o at user_go", fail_o, 1'b0);
    step();
    check("R7", "user_go_o one cycle", user_go_o, 1'b0);
    repeat (5) step();
    check("R7", "fail_o stays low", fail_o, 1'b0);
  endtask

  task automatic t_ist_fail();
    apply_reset(20, 1'b0, 1'b0);
    step(); step();
    ist_done = 1'b1; ist_pass = 1'b0;
    step();
    ist_done = 1'b0;
    check("R6", "fail_o after internal fail", fail_o, 1'b1);
    bus_done = 1'b1; bus_pass = 1'b1; ist_done = 1'b1; ist_pass = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step();
      if (bus_start_o !== 1'b0 || user_go_o !== 1'b0 || fail_o !== 1'b1)
        check("R6", "halt held", 1'b0, 1'b1);
    end
    bus_done = 1'b0; bus_pass = 1'b0; ist_done = 1'b0; ist_pass = 1'b0;
    check("R6", "fail_o still high", fail_o, 1'b1);
    check("R6", "user_go_o still low", user_go_o, 1'b0);
  endtask

  task automatic t_bus_fail();
    apply_reset(16, 1'b0, 1'b0);
    step(); step();
    ist_done = 1'b1; ist_pass = 1'b1;
    step();
    ist_done = 1'b0; ist_pass = 1'b0;
    step(); step();
    bus_done = 1'b1; bus_pass = 1'b0;
    step();
    bus_done = 1'b0;
    check("R8", "fail_o after bus fail", fail_o, 1'b1);
    check("R8", "user_go_o after bus fail", user_go_o, 1'b0);
    for (int i = 0; i < 5; i++) begin
      step();
      if (user_go_o !== 1'b0 || fail_o !== 1'b1)
        check("R8", "bus halt held", 1'b0, 1'b1);
    end
  endtask

  task automatic t_bypass();
    apply_reset(16, 1'b0, 1'b1);
    step();
    check("R9", "user_go_o right after release", user_go_o, 1'b1);
    check("R9", "fail_o in bypass", fail_o, 1'b0);
    check("R9", "ist_start_o in bypass", ist_start_o, 1'b0);
    for (int i = 0; i < 8; i++) begin
      step();
      if (fail_o !== 1'b0 || ist_start_o !== 1'b0 || bus_start_o !== 1'b0 || user_go_o !== 1'b0)
        check("R9", "quiet in bypass", 1'b0, 1'b1);
    end
    bist_skip = 1'b0;
  endtask

  task automatic t_width(input int n, input logic mode, input string req);
    apply_reset(n, mode, 1'b0);
    step();
    check(req, $sformatf("short_rst_o hold=%0d mode1x=%0b", n, mode),
          short_rst_o, expect_short(n, mode));
    check("R2", "sequence proceeds", ist_start_o, 1'b1);
    repeat (4) step();
    check("R2", "short_rst_o sticky", short_rst_o, expect_short(n, mode));
  endtask

  task automatic t_abort();
    apply_reset(15, 1'b0, 1'b0);
    step();
    check("R2", "short flag on 15 in 2x", short_rst_o, 1'b1);
    step();
    rst_pin = 1'b1;
    step();
    check("R10", "fail_o after abort", fail_o, 1'b0);
    check("R10", "short_rst_o after abort", short_rst_o, 1'b0);
    repeat (20) @(posedge clk);
    @(negedge clk);
    rst_pin = 1'b0;
    step();
    check("R10", "restart ist_start_o", ist_start_o, 1'b1);
    check("R10", "restart fail_o", fail_o, 1'b1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !finished) begin
        finished = 1'b1;
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
      end
    end
  end

  initial begin
    t_reset_state();
    t_full_pass();
    t_ist_fail();
    t_bus_fail();
    t_bypass();
    t_abort();
    t_width(16, 1'b1, "R2");
    t_width(9999, 1'b1, "R2");
    t_width(10000, 1'b1, "R2");
    t_width(17000, 1'b1, "R3");
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule